// File: doc/BRIEF.md
# Journaled Parameter Record Store

This block keeps one set of operating parameters in the top 4096 bytes of a byte-addressed flash. That region is a single erase unit. It is split into 128 slots of 32 bytes. Byte 0 of each slot is a status byte, and bytes 1 to 31 carry the 31-byte payload. A record is never changed in place. Each store appends the new payload to the next blank slot, marks that slot valid, and only then marks the previous slot superseded. The whole region is erased only when a store finds no blank slot left. This spreads programming across the region and keeps the slow erase rare.

After reset the block scans the status bytes from slot 0 upward. It stops at the first valid slot, fetches that slot's payload and presents it. When no slot is valid it reports an empty store and remembers the first blank slot. The user side has two single-cycle commands, load and store, a 31-byte write bus, a 31-byte read bus, a valid flag and a busy flag.

The flash side issues one byte read, one byte program or one region erase at a time. A request is a one-cycle pulse, given only while the flash busy input is low. The flash must raise its busy flag in the cycle after the request and lower it when the operation completes. Read data must be valid and held from that point until the next request.

The controller states are:
- SCAN (status read) and SCAN_W: go to FETCH on a valid status, to IDLE after the last slot, and otherwise back to SCAN.
- FETCH and FETCH_W: read one payload byte. Go to IDLE after the last byte.
- IDLE:
  - A store goes to WIPE when the region is full and to FILL otherwise.
  - A load goes to FETCH when a record is held.
- WIPE and WIPE_W: erase, then go to FILL at slot 0.
- FILL and FILL_W: program one payload byte. Go to SEAL after the last byte.
- SEAL and SEAL_W: program the valid status. Go to RETIRE when an older record exists, and otherwise commit to IDLE.
- RETIRE and RETIRE_W: supersede the old slot, then commit to IDLE.

Top module: `jps_store`

## Requirements
- R1: After reset, busy is high while the scan runs. When it falls, rec_valid is 1 and rd_data holds the payload of the lowest-numbered slot whose status is valid. If no slot is valid, rec_valid is 0 and rd_data is zero.
- R2: Every flash request addresses the top 4096 bytes of the flash. Byte j of slot i is at region offset 32*i + j, with the status in byte 0 and payload byte k in byte k+1.
- R3: Status byte codes are 0xFF blank, 0x7F valid and 0x00 superseded. A status byte is only ever programmed from 0xFF to 0x7F or from 0x7F to 0x00.
- R4: A store programs the slot after the current valid slot. In an empty store it programs the first blank slot found by the scan. Every payload byte it programs was 0xFF beforehand.
- R5: A store programs the payload bytes, then the new status 0x7F, and only then the old slot's status 0x00. When an old status is cleared, at least one other valid record already exists.
- R6: A store issued when all 128 slots are used causes exactly one region erase. The store then writes the record to slot 0, and every other slot is left blank. No erase happens before that point.
- R7: A load while a record is held reads the 31 payload bytes again from flash into rd_data. A load on an empty store does nothing: busy stays low and no flash access is made.
- R8: busy is high for the whole of every flash sequence. A load or store that arrives while busy is high is ignored.
- R9: When load and store arrive in the same cycle, the store is performed and the load is dropped.
- R10: At most one flash request is active at a time. It lasts one cycle and is given only while the flash busy input is low.
- R11: When busy falls after a store, rec_valid is 1 and rd_data equals the stored payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Load command pulse |
| cmd_store | input | 1 | Store command pulse |
| wr_data | input | 248 | Payload to store, byte k in bits 8k+7:8k |
| busy | output | 1 | Sequence in progress |
| rec_valid | output | 1 | A valid record is held |
| rd_data | output | 248 | Current payload |
| fl_rd | output | 1 | Flash byte read request |
| fl_prog | output | 1 | Flash byte program request |
| fl_erase | output | 1 | Flash region erase request |
| fl_addr | output | 24 | Flash byte address |
| fl_wdata | output | 8 | Byte to program |
| fl_busy | input | 1 | Flash operation in progress |
| fl_rdata | input | 8 | Byte read from flash |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a load and a store arriving together. The bench raises both in one cycle and expects a stored record with no new flash reads. It judges this from the flash read count kept by its flash model and from the flash image.

The second pair is a store command landing in a cycle when busy is already high from an earlier store. The bench judges this from the flash image: the slot after the new record must still be blank. The reference model compares rec_valid and rd_data against its own expectation on every idle clock.

// File: rtl/jps_pkg.sv
package jps_pkg;

    localparam logic [7:0] STAT_BLANK = 8'hFF;
    localparam logic [7:0] STAT_VALID = 8'h7F;
    localparam logic [7:0] STAT_DEAD  = 8'h00;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } fl_op_e;

    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_ISSUE = 2'd1,
        P_WAIT  = 2'd2
    } port_state_e;

    typedef enum logic [3:0] {
        S_SCAN     = 4'd0,
        S_SCAN_W   = 4'd1,
        S_FETCH    = 4'd2,
        S_FETCH_W  = 4'd3,
        S_IDLE     = 4'd4,
        S_WIPE     = 4'd5,
        S_WIPE_W   = 4'd6,
        S_FILL     = 4'd7,
        S_FILL_W   = 4'd8,
        S_SEAL     = 4'd9,
        S_SEAL_W   = 4'd10,
        S_RETIRE   = 4'd11,
        S_RETIRE_W = 4'd12
    } ctl_state_e;

endpackage

// File: rtl/jps_slot_addr.sv
module jps_slot_addr #(
    parameter int FL_AW  = 24,
    parameter int SLOT_W = 7,
    parameter int BYTE_W = 5
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [BYTE_W-1:0] offs,
    output logic [FL_AW-1:0]  addr
);
    localparam int RG_W = SLOT_W + BYTE_W;

    // The region is the last erase unit, so every bit above it is one.
    generate
        if (FL_AW > RG_W) begin : g_pad
            assign addr = {{(FL_AW-RG_W){1'b1}}, slot, offs};
        end else begin : g_flat
            assign addr = {slot, offs};
        end
    endgenerate
endmodule

// File: rtl/jps_rec_buf.sv
module jps_rec_buf #(
    parameter int PAY_BYTES = 31,
    parameter int IDX_W     = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_all,
    input  logic [8*PAY_BYTES-1:0] all_in,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_byte,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [7:0]             rd_byte,
    output logic [8*PAY_BYTES-1:0] flat
);
    logic [7:0] q [PAY_BYTES];

    generate
        for (genvar i = 0; i < PAY_BYTES; i++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q[i] <= 8'h00;
                end else if (ld_all) begin
                    q[i] <= all_in[8*i +: 8];
                end else if (wr_en && wr_idx == IDX_W'(i)) begin
                    q[i] <= wr_byte;
                end
            end
            assign flat[8*i +: 8] = q[i];
        end
    endgenerate

    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < PAY_BYTES; i++) begin
            if (rd_idx == IDX_W'(i)) rd_byte = q[i];
        end
    end
endmodule

// File: rtl/jps_flash_port.sv
module jps_flash_port
    import jps_pkg::*;
#(
    parameter int FL_AW = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  fl_op_e           op_kind,
    input  logic [FL_AW-1:0] op_addr,
    input  logic [7:0]       op_wdata,
    output logic             op_done,
    output logic [7:0]       op_rdata,
    output logic             fl_rd,
    output logic             fl_prog,
    output logic             fl_erase,
    output logic [FL_AW-1:0] fl_addr,
    output logic [7:0]       fl_wdata,
    input  logic             fl_busy,
    input  logic [7:0]       fl_rdata
);
    port_state_e      st;
    fl_op_e           kind_q;
    logic [FL_AW-1:0] addr_q;
    logic [7:0]       wdata_q;
    logic             fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= P_IDLE;
            kind_q  <= OP_READ;
            addr_q  <= '0;
            wdata_q <= 8'h00;
        end else begin
            unique case (st)
                P_IDLE: begin
                    if (op_start) begin
                        kind_q  <= op_kind;
                        addr_q  <= op_addr;
                        wdata_q <= op_wdata;
                        st      <= P_ISSUE;
                    end
                end
                P_ISSUE: if (!fl_busy) st <= P_WAIT;
                P_WAIT:  if (!fl_busy) st <= P_IDLE;
                default: st <= P_IDLE;
            endcase
        end
    end

    always_comb begin
        fire     = (st == P_ISSUE) && !fl_busy;
        fl_rd    = fire && (kind_q == OP_READ);
        fl_prog  = fire && (kind_q == OP_PROG);
        fl_erase = fire && (kind_q == OP_ERASE);
        fl_addr  = addr_q;
        fl_wdata = wdata_q;
        op_done  = (st == P_WAIT) && !fl_busy;
        op_rdata = fl_rdata;
    end

    // R10
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_rd || fl_prog || fl_erase) |=> !(fl_rd || fl_prog || fl_erase));

    // R10
    req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_rd || fl_prog || fl_erase) |-> !fl_busy);
endmodule

// File: rtl/jps_store.sv
module jps_store
    import jps_pkg::*;
#(
    parameter int FL_AW        = 24,
    parameter int REGION_BYTES = 4096,
    parameter int REC_BYTES    = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cmd_load,
    input  logic                                 cmd_store,
    input  logic [8*(REC_BYTES-1)-1:0]           wr_data,
    output logic                                 busy,
    output logic                                 rec_valid,
    output logic [8*(REC_BYTES-1)-1:0]           rd_data,
    output logic                                 fl_rd,
    output logic                                 fl_prog,
    output logic                                 fl_erase,
    output logic [FL_AW-1:0]                     fl_addr,
    output logic [7:0]                           fl_wdata,
    input  logic                                 fl_busy,
    input  logic [7:0]                           fl_rdata
);
    localparam int SLOTS     = REGION_BYTES / REC_BYTES;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int BYTE_W    = $clog2(REC_BYTES);
    localparam int CNT_W     = SLOT_W + 1;
    localparam int PAY_BYTES = REC_BYTES - 1;
    localparam int PAY_W     = 8 * PAY_BYTES;
    localparam logic [BYTE_W-1:0] LAST_OFF  = BYTE_W'(REC_BYTES - 1);
    localparam logic [CNT_W-1:0]  LAST_SLOT = CNT_W'(SLOTS - 1);
    localparam logic [CNT_W-1:0]  FULL_MARK = CNT_W'(SLOTS);

    ctl_state_e         state;
    logic [CNT_W-1:0]   slot_idx;
    logic [BYTE_W-1:0]  byte_idx;
    logic [SLOT_W-1:0]  cur_slot;
    logic [CNT_W-1:0]   next_slot;
    logic               have_valid;
    logic               blank_seen;
    logic [SLOT_W-1:0]  first_blank;

    logic               op_start;
    fl_op_e             op_kind;
    logic [7:0]         op_wdata;
    logic               op_done;
    logic [7:0]         op_rdata;
    logic [SLOT_W-1:0]  a_slot;
    logic [BYTE_W-1:0]  a_offs;
    logic [FL_AW-1:0]   a_addr;

    logic               buf_ld;
    logic               buf_wr;
    logic [BYTE_W-1:0]  buf_idx;
    logic [7:0]         buf_byte;
    logic [PAY_W-1:0]   buf_flat;

    jps_slot_addr #(.FL_AW(FL_AW), .SLOT_W(SLOT_W), .BYTE_W(BYTE_W)) u_addr (
        .slot (a_slot),
        .offs (a_offs),
        .addr (a_addr)
    );

    jps_flash_port #(.FL_AW(FL_AW)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .op_kind  (op_kind),
        .op_addr  (a_addr),
        .op_wdata (op_wdata),
        .op_done  (op_done),
        .op_rdata (op_rdata),
        .fl_rd    (fl_rd),
        .fl_prog  (fl_prog),
        .fl_erase (fl_erase),
        .fl_addr  (fl_addr),
        .fl_wdata (fl_wdata),
        .fl_busy  (fl_busy),
        .fl_rdata (fl_rdata)
    );

    jps_rec_buf #(.PAY_BYTES(PAY_BYTES), .IDX_W(BYTE_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_all  (buf_ld),
        .all_in  (wr_data),
        .wr_en   (buf_wr),
        .wr_idx  (buf_idx),
        .wr_byte (op_rdata),
        .rd_idx  (buf_idx),
        .rd_byte (buf_byte),
        .flat    (buf_flat)
    );

    // State register and the counters and pointers it steps.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= S_SCAN;
            slot_idx    <= '0;
            byte_idx    <= '0;
            cur_slot    <= '0;
            next_slot   <= '0;
            have_valid  <= 1'b0;
            blank_seen  <= 1'b0;
            first_blank <= '0;
        end else begin
            unique case (state)
                S_SCAN: state <= S_SCAN_W;
                S_SCAN_W: begin
                    if (op_done) begin
                        if (op_rdata == STAT_VALID) begin
                            cur_slot   <= slot_idx[SLOT_W-1:0];
                            next_slot  <= slot_idx + 1'b1;
                            have_valid <= 1'b1;
                            byte_idx   <= BYTE_W'(1);
                            state      <= S_FETCH;
                        end else begin
                            if (op_rdata == STAT_BLANK && !blank_seen) begin
                                blank_seen  <= 1'b1;
                                first_blank <= slot_idx[SLOT_W-1:0];
                            end
                            if (slot_idx == LAST_SLOT) begin
                                have_valid <= 1'b0;
                                if (blank_seen)
                                    next_slot <= {1'b0, first_blank};
                                else if (op_rdata == STAT_BLANK)
                                    next_slot <= slot_idx;
                                else
                                    next_slot <= FULL_MARK;
                                state <= S_IDLE;
                            end else begin
                                slot_idx <= slot_idx + 1'b1;
                                state    <= S_SCAN;
                            end
                        end
                    end
                end
                S_FETCH: state <= S_FETCH_W;
                S_FETCH_W: begin
                    if (op_done) begin
                        if (byte_idx == LAST_OFF) begin
                            state <= S_IDLE;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                            state    <= S_FETCH;
                        end
                    end
                end
                S_IDLE: begin
                    if (cmd_store) begin
                        byte_idx <= BYTE_W'(1);
                        state    <= (next_slot == FULL_MARK) ? S_WIPE : S_FILL;
                    end else if (cmd_load && have_valid) begin
                        byte_idx <= BYTE_W'(1);
                        state    <= S_FETCH;
                    end
                end
                S_WIPE: state <= S_WIPE_W;
                S_WIPE_W: begin
                    if (op_done) begin
                        next_slot  <= '0;
                        have_valid <= 1'b0;
                        byte_idx   <= BYTE_W'(1);
                        state      <= S_FILL;
                    end
                end
                S_FILL: state <= S_FILL_W;
                S_FILL_W: begin
                    if (op_done) begin
                        if (byte_idx == LAST_OFF) begin
                            state <= S_SEAL;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                            state    <= S_FILL;
                        end
                    end
                end
                S_SEAL: state <= S_SEAL_W;
                S_SEAL_W: begin
                    if (op_done) begin
                        if (have_valid) begin
                            state <= S_RETIRE;
                        end else begin
                            cur_slot   <= next_slot[SLOT_W-1:0];
                            next_slot  <= next_slot + 1'b1;
                            have_valid <= 1'b1;
                            state      <= S_IDLE;
                        end
                    end
                end
                S_RETIRE: state <= S_RETIRE_W;
                S_RETIRE_W: begin
                    if (op_done) begin
                        cur_slot   <= next_slot[SLOT_W-1:0];
                        next_slot  <= next_slot + 1'b1;
                        have_valid <= 1'b1;
                        state      <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs and the controls fanned out to the port and buffer.
    always_comb begin
        op_start = 1'b0;
        op_kind  = OP_READ;
        op_wdata = STAT_BLANK;
        a_slot   = cur_slot;
        a_offs   = '0;
        buf_ld   = 1'b0;
        buf_wr   = 1'b0;
        buf_idx  = byte_idx - 1'b1;
        unique case (state)
            S_SCAN: begin
                op_start = 1'b1;
                a_slot   = slot_idx[SLOT_W-1:0];
            end
            S_FETCH: begin
                op_start = 1'b1;
                a_offs   = byte_idx;
            end
            S_FETCH_W: buf_wr = op_done;
            S_IDLE:    buf_ld = cmd_store;
            S_WIPE: begin
                op_start = 1'b1;
                op_kind  = OP_ERASE;
                a_slot   = '0;
            end
            S_FILL: begin
                op_start = 1'b1;
                op_kind  = OP_PROG;
                a_slot   = next_slot[SLOT_W-1:0];
                a_offs   = byte_idx;
                op_wdata = buf_byte;
            end
            S_SEAL: begin
                op_start = 1'b1;
                op_kind  = OP_PROG;
                a_slot   = next_slot[SLOT_W-1:0];
                op_wdata = STAT_VALID;
            end
            S_RETIRE: begin
                op_start = 1'b1;
                op_kind  = OP_PROG;
                op_wdata = STAT_DEAD;
            end
            default: ;
        endcase
        busy      = (state != S_IDLE);
        rec_valid = have_valid;
        rd_data   = buf_flat;
    end

    // R8
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_rd || fl_prog || fl_erase) |-> busy);

    // R3
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_prog && fl_addr[BYTE_W-1:0] == '0) |->
            (fl_wdata == STAT_VALID || fl_wdata == STAT_DEAD));

    // R6
    erase_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_erase |-> (next_slot == FULL_MARK));

    // R11
    commit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_prog && fl_wdata == STAT_DEAD) |=> !rec_valid || $stable(rec_valid));
endmodule

// File: tb/tb_jps_store.sv
module tb_jps_store;
    localparam int PW = 248;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_load = 1'b0;
    logic          cmd_store = 1'b0;
    logic [PW-1:0] wr_data = '0;
    logic          busy, rec_valid, fl_rd, fl_prog, fl_erase;
    logic [PW-1:0] rd_data;
    logic [23:0]   fl_addr;
    logic [7:0]    fl_wdata;
    logic          fbusy = 1'b0;
    logic [7:0]    frd = 8'h00;

    always #2 clk = ~clk;

    jps_store dut (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_store(cmd_store),
        .wr_data(wr_data), .busy(busy), .rec_valid(rec_valid), .rd_data(rd_data),
        .fl_rd(fl_rd), .fl_prog(fl_prog), .fl_erase(fl_erase), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_busy(fbusy), .fl_rdata(frd)
    );

    function automatic logic [PW-1:0] mk_pay(int seed);
        logic [PW-1:0] v;
        for (int k = 0; k < 31; k++) v[8*k +: 8] = 8'((seed * 37 + k * 11 + 5) & 255);
        return v;
    endfunction

    // Behavioural flash model with its own checks.
    logic [7:0] mem [4096];
    int fcnt = 0;
    int pre_op = 0;
    int fm_chk = 0, fm_bad = 0, fm_reads = 0, fm_erases = 0;

    always @(posedge clk) begin
        int a, nv;
        logic [PW-1:0] pp;
        if (fcnt > 0) begin
            fcnt <= fcnt - 1;
            if (fcnt == 1) fbusy <= 1'b0;
        end
        if (pre_op != 0) begin
            pp = mk_pay(77);
            for (int i = 0; i < 4096; i++) mem[i] <= 8'hFF;
            if (pre_op == 2) begin
                for (int s = 0; s < 3; s++)
                    for (int j = 0; j < 32; j++) mem[s*32 + j] <= 8'h00;
            end
            if (pre_op == 3) begin
                for (int s = 0; s < 5; s++)
                    for (int j = 0; j < 32; j++) mem[s*32 + j] <= 8'h00;
                mem[160] <= 8'h7F;
                for (int k = 0; k < 31; k++) mem[161 + k] <= pp[8*k +: 8];
            end
        end else if (fl_rd || fl_prog || fl_erase) begin
            fm_chk++;
            if (fl_addr[23:12] != 12'hFFF) begin
                fm_bad++;
                $display("FAIL R2 address outside region act=%h exp=FFFxxx", fl_addr);
            end
            fm_chk++;
            if (fbusy) begin
                fm_bad++;
                $display("FAIL R10 request while flash busy act=1 exp=0");
            end
            fbusy <= 1'b1;
            a = int'(fl_addr[11:0]);
            if (fl_rd) begin
                frd <= mem[a];
                fm_reads++;
                fcnt <= 2;
            end
            if (fl_prog) begin
                fcnt <= 3;
                fm_chk++;
                if (a % 32 == 0) begin
                    if (!((mem[a] == 8'hFF && fl_wdata == 8'h7F) ||
                          (mem[a] == 8'h7F && fl_wdata == 8'h00))) begin
                        fm_bad++;
                        $display("FAIL R3 status step act=%h->%h exp=FF->7F or 7F->00", mem[a], fl_wdata);
                    end
                    if (fl_wdata == 8'h00) begin
                        nv = 0;
                        for (int s = 0; s < 128; s++) if (mem[s*32] == 8'h7F) nv++;
                        fm_chk++;
                        if (nv < 2) begin
                            fm_bad++;
                            $display("FAIL R5 retire before new record valid act=%0d exp>=2", nv);
                        end
                    end
                end else if (mem[a] != 8'hFF) begin
                    fm_bad++;
                    $display("FAIL R4 program of non-blank byte act=%h exp=FF", mem[a]);
                end
                mem[a] <= mem[a] & fl_wdata;
            end
            if (fl_erase) begin
                fcnt <= 40;
                fm_erases++;
                for (int i = 0; i < 4096; i++) mem[i] <= 8'hFF;
            end
        end
    end

    // Reference model state.
    int            m_stat [128];
    logic [PW-1:0] m_pay  [128];
    int            m_cur = -1, m_next = 0;
    logic          exp_valid = 1'b0;
    logic [PW-1:0] exp_data = '0;
    int cmp_chk = 0, cmp_bad = 0;

    // Per-clock comparison of user outputs whenever the block is idle.
    always @(negedge clk) begin
        if (rst_n && !busy) begin
            cmp_chk++;
            if (rec_valid !== exp_valid || rd_data !== exp_data) begin
                cmp_bad++;
                $display("FAIL R11 idle outputs act=%b/%h exp=%b/%h", rec_valid, rd_data, exp_valid, exp_data);
            end
        end
    end

    int total = 0, bad = 0;

    task automatic chk(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (busy && n < 20000);
    endtask

    task automatic model_rescan();
        m_cur = -1;
        m_next = 128;
        for (int s = 0; s < 128; s++) begin
            if (m_cur < 0 && m_stat[s] == 8'h7F) m_cur = s;
        end
        if (m_cur >= 0) begin
            m_next = m_cur + 1;
            exp_valid = 1'b1;
            exp_data = m_pay[m_cur];
        end else begin
            for (int s = 127; s >= 0; s--) if (m_stat[s] == 8'hFF) m_next = s;
            exp_valid = 1'b0;
            exp_data = '0;
        end
    endtask

    task automatic do_reset(int pre);
        @(posedge clk); #1;
        rst_n = 1'b0;
        pre_op = pre;
        @(posedge clk); #1;
        pre_op = 0;
        if (pre != 0) begin
            for (int s = 0; s < 128; s++) m_stat[s] = 8'hFF;
            if (pre == 2) for (int s = 0; s < 3; s++) m_stat[s] = 8'h00;
            if (pre == 3) begin
                for (int s = 0; s < 5; s++) m_stat[s] = 8'h00;
                m_stat[5] = 8'h7F;
                m_pay[5] = mk_pay(77);
            end
        end
        model_rescan();
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy during scan", PW'(busy), PW'(1));
        wait_idle();
    endtask

    task automatic model_store(logic [PW-1:0] d);
        if (m_next == 128) begin
            for (int s = 0; s < 128; s++) m_stat[s] = 8'hFF;
            m_cur = -1;
            m_next = 0;
        end
        m_stat[m_next] = 8'h7F;
        m_pay[m_next] = d;
        if (m_cur >= 0) m_stat[m_cur] = 8'h00;
        m_cur = m_next;
        m_next++;
        exp_valid = 1'b1;
        exp_data = d;
    endtask

    task automatic do_store(logic [PW-1:0] d);
        @(posedge clk); #1;
        cmd_store = 1'b1;
        wr_data = d;
        @(posedge clk); #1;
        cmd_store = 1'b0;
        model_store(d);
    endtask

    task automatic do_load();
        @(posedge clk); #1;
        cmd_load = 1'b1;
        @(posedge clk); #1;
        cmd_load = 1'b0;
    endtask

    task automatic check_image(string req);
        int nbad = 0, first = -1;
        logic [PW-1:0] got = '0;
        for (int s = 0; s < 128; s++) begin
            if (int'(mem[s*32]) != m_stat[s]) begin
                nbad++;
                if (first < 0) first = s;
            end
        end
        chk(nbad == 0, req, PW'(first < 0 ? 0 : mem[first*32]),
            PW'(first < 0 ? 0 : m_stat[first]));
        if (m_cur >= 0) begin
            for (int k = 0; k < 31; k++) got[8*k +: 8] = mem[m_cur*32 + 1 + k];
            chk(got == m_pay[m_cur], req, got, m_pay[m_cur]);
        end
    endtask

    task automatic run_all();
        int r0, e0;
        // R1: empty region
        do_reset(1);
        chk(rec_valid == 1'b0, "R1 empty after scan", PW'(rec_valid), PW'(0));
        chk(rd_data == '0, "R1 empty data", rd_data, '0);

        // R7: load on empty store
        r0 = fm_reads;
        do_load();
        @(negedge clk);
        chk(busy == 1'b0, "R7 empty load stays idle", PW'(busy), PW'(0));
        chk(fm_reads == r0, "R7 empty load no reads", PW'(fm_reads), PW'(r0));

        // R4 R5 R11: first and second store
        do_store(mk_pay(1));
        wait_idle();
        chk(rd_data == mk_pay(1) && rec_valid, "R11 store result", rd_data, mk_pay(1));
        check_image("R4 first store image");
        do_store(mk_pay(2));
        wait_idle();
        check_image("R5 second store supersedes slot 0");
        chk(mem[0] == 8'h00 && mem[32] == 8'h7F, "R3 status codes", PW'({mem[0], mem[32]}), PW'(16'h007F));

        // R9: load and store together
        r0 = fm_reads;
        @(posedge clk); #1;
        cmd_load = 1'b1;
        cmd_store = 1'b1;
        wr_data = mk_pay(3);
        @(posedge clk); #1;
        cmd_load = 1'b0;
        cmd_store = 1'b0;
        model_store(mk_pay(3));
        wait_idle();
        chk(fm_reads == r0, "R9 load dropped", PW'(fm_reads), PW'(r0));
        check_image("R9 store taken");

        // R8: store while busy is ignored
        do_store(mk_pay(4));
        repeat (5) @(posedge clk);
        #1;
        cmd_store = 1'b1;
        wr_data = mk_pay(99);
        @(posedge clk); #1;
        cmd_store = 1'b0;
        wait_idle();
        check_image("R8 busy store ignored");
        chk(mem[m_next*32] == 8'hFF, "R8 next slot blank", PW'(mem[m_next*32]), PW'(8'hFF));

        // R7: load rereads payload
        r0 = fm_reads;
        do_load();
        wait_idle();
        chk(fm_reads == r0 + 31, "R7 load reads payload", PW'(fm_reads), PW'(r0 + 31));

        // R1: rescan finds the record written before
        do_reset(0);
        chk(rec_valid && rd_data == mk_pay(4), "R1 rescan finds slot", rd_data, mk_pay(4));

        // R6: fill all slots, then wrap
        e0 = fm_erases;
        for (int i = m_next; i < 128; i++) begin
            do_store(mk_pay(100 + i));
            wait_idle();
        end
        chk(fm_erases == e0, "R6 no early erase", PW'(fm_erases), PW'(e0));
        check_image("R6 full image");
        do_store(mk_pay(500));
        wait_idle();
        chk(fm_erases == e0 + 1, "R6 single erase", PW'(fm_erases), PW'(e0 + 1));
        chk(m_cur == 0, "R6 model at slot 0", PW'(m_cur), PW'(0));
        check_image("R6 wrapped image");

        // R4: empty store with superseded slots uses first blank
        do_reset(2);
        chk(rec_valid == 1'b0, "R1 superseded only is empty", PW'(rec_valid), PW'(0));
        do_store(mk_pay(7));
        wait_idle();
        chk(mem[96] == 8'h7F, "R4 first blank slot used", PW'(mem[96]), PW'(8'h7F));
        check_image("R4 blank search image");

        // R1 R2: valid record in a later slot
        do_reset(3);
        chk(rec_valid && rd_data == mk_pay(77), "R1 scan slot 5", rd_data, mk_pay(77));
        do_store(mk_pay(8));
        wait_idle();
        check_image("R2 slot 6 layout");
    endtask

    initial begin
        bit wd = 1'b0;
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            bad++;
            total++;
            $display("FAIL watchdog act=timeout exp=finish");
        end
        $display("test done: total=%0d bad=%0d", total + cmp_chk + fm_chk, bad + cmp_bad + fm_bad);
        $finish;
    end
endmodule